// File: doc/BRIEF.md
# Bitfield Insert and Extract Unit

This unit does the field handling steps of a small macro execution engine. It takes two 32-bit register operands, A and B, two immediate bit positions (a source position and a destination position), an immediate field width and a 2-bit mode. It builds one 32-bit result. The first mode writes a field cut from B into a copy of A. The other two modes cut a field out of B and shift it left. In one of them the cut position comes from register A. In the other, the left shift distance comes from register A.

The datapath is purely combinational. A single register on the output gives a clean timing boundary, so the result for the operands presented at one rising clock edge appears after that edge. The register file and write-back stay outside the unit.

Top module: `bitfield_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes zero after that edge.
- R2: With `rst` low, `result` after each rising edge is the function of the inputs sampled at that edge, so the latency is one cycle.
- R3: Mode 0 (insert) takes the field of `fld_width` bits of B that starts at `src_pos`. It returns A with the `fld_width` bits starting at `dst_pos` replaced by that field. All other bits of A are unchanged.
- R4: The field mask is `fld_width` consecutive ones starting at bit 0. A width of zero makes mode 0 return A unchanged and makes modes 1 and 2 return zero.
- R5: Mode 1 (dynamic position) returns ((B >> A) & mask) << `dst_pos`.
- R6: Mode 2 (dynamic shift) returns ((B >> `src_pos`) & mask) << A.
- R7: In modes 1 and 2, a value of A of 32 or more gives a zero result. Otherwise bits 4:0 of A set the distance.
- R8: Bits shifted past bit 31 are lost, and bits above bit 31 of B read as zero. In mode 2 all result bits below the shift distance taken from A are zero.
- R9: Mode 3 is unused and returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 insert, 1 dynamic position, 2 dynamic shift, 3 unused |
| opnd_a | input | 32 | Register operand A |
| opnd_b | input | 32 | Register operand B |
| src_pos | input | 5 | Immediate bit position of the field in B |
| dst_pos | input | 5 | Immediate bit position of the field in the result |
| fld_width | input | 5 | Field width in bits |
| result | output | 32 | Registered result |

## Verification
The bench targets fields that run past bit 31, either at the source or at the destination. A design that wraps bits around or keeps bits above bit 31 would show stray high or low bits there. It drives A with values of 32 and above and with values whose upper bits are set. A design that kept only bits 4:0 of A would then return a shifted field where zero is required. Width zero and width 31 are driven at both edges of the operand. Here a mask built one bit off, or an insert that clears the wrong span of A, shows up as a one-bit difference against the bit-by-bit reference model. Mode 3 and a reset in the middle of a run check that no stale value is left at the output.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int DW = 32;
    localparam int PW = $clog2(DW);

    typedef logic [DW-1:0] word_t;
    typedef logic [PW-1:0] pos_t;

    typedef enum logic [1:0] {
        MODE_INSERT     = 2'd0,
        MODE_DYN_POS    = 2'd1,
        MODE_DYN_SHIFT  = 2'd2,
        MODE_IDLE       = 2'd3
    } bf_mode_e;

    // A shift distance together with a flag saying it lies inside the word
    typedef struct packed {
        pos_t pos;
        logic ok;
    } shift_sel_t;

    // Distance taken from a register: out of range when any upper bit is set
    function automatic shift_sel_t dyn_shift(word_t v);
        shift_sel_t sel;
        sel.pos = v[PW-1:0];
        sel.ok  = ((v >> PW) == '0);
        return sel;
    endfunction

    // Distance taken from an immediate field: always in range
    function automatic shift_sel_t imm_shift(pos_t p);
        shift_sel_t sel;
        sel.pos = p;
        sel.ok  = 1'b1;
        return sel;
    endfunction

endpackage

// File: rtl/bf_mask_gen.sv
module bf_mask_gen
    import bfu_pkg::*;
(
    input  pos_t  width,
    output word_t mask
);
    // One comparator per bit: bit i is set when it lies below the width
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign mask[i] = (width > PW'(i));
    end
endmodule

// File: rtl/bf_extract.sv
module bf_extract
    import bfu_pkg::*;
(
    input  word_t      data,
    input  shift_sel_t sel,
    input  word_t      mask,
    output word_t      field
);
    always_comb begin
        if (sel.ok) field = (data >> sel.pos) & mask;
        else        field = '0;
    end
endmodule

// File: rtl/bf_place.sv
module bf_place
    import bfu_pkg::*;
(
    input  word_t      data,
    input  shift_sel_t sel,
    output word_t      placed
);
    always_comb begin
        if (sel.ok) placed = data << sel.pos;
        else        placed = '0;
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  mode,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [4:0]  src_pos,
    input  logic [4:0]  dst_pos,
    input  logic [4:0]  fld_width,
    output logic [31:0] result
);
    bf_mode_e   op;
    shift_sel_t ext_sel;
    shift_sel_t put_sel;
    shift_sel_t dst_sel;
    word_t      mask;
    word_t      field;
    word_t      placed;
    word_t      hole;
    word_t      next_res;

    assign op      = bf_mode_e'(mode);
    assign ext_sel = (op == MODE_DYN_POS)   ? dyn_shift(opnd_a) : imm_shift(src_pos);
    assign put_sel = (op == MODE_DYN_SHIFT) ? dyn_shift(opnd_a) : imm_shift(dst_pos);
    assign dst_sel = imm_shift(dst_pos);

    bf_mask_gen u_mask (
        .width (fld_width),
        .mask  (mask)
    );

    bf_extract u_ext (
        .data  (opnd_b),
        .sel   (ext_sel),
        .mask  (mask),
        .field (field)
    );

    bf_place u_put (
        .data   (field),
        .sel    (put_sel),
        .placed (placed)
    );

    // Span of A that an insert overwrites
    bf_place u_hole (
        .data   (mask),
        .sel    (dst_sel),
        .placed (hole)
    );

    always_comb begin
        unique case (op)
            MODE_INSERT:    next_res = (opnd_a & ~hole) | placed;
            MODE_DYN_POS,
            MODE_DYN_SHIFT: next_res = placed;
            default:        next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= next_res;
    end
endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode,
    input logic [31:0] opnd_a,
    input logic [4:0]  dst_pos,
    input logic [4:0]  fld_width,
    input logic [31:0] result
);
    AST_EMPTY_INSERT_KEEPS_A: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && fld_width == 5'd0) |=> (result == $past(opnd_a))); // R4

    AST_EMPTY_PULL_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd1 || mode == 2'd2) && fld_width == 5'd0) |=> (result == 32'd0)); // R4

    AST_DYN_RANGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((mode == 2'd1 || mode == 2'd2) && opnd_a[31:5] != 27'd0) |=> (result == 32'd0)); // R7

    AST_IDLE_MODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |=> (result == 32'd0)); // R9

    AST_PULL_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |=> ($countones(result) <= int'($past(fld_width)))); // R5

    AST_SHIFT_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && opnd_a[31:5] == 27'd0) |=>
        ((result & ((32'd1 << $past(opnd_a[4:0])) - 32'd1)) == 32'd0)); // R8
endmodule

bind bitfield_unit bitfield_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .opnd_a    (opnd_a),
    .dst_pos   (dst_pos),
    .fld_width (fld_width),
    .result    (result)
);

// File: tb/sim_bitfield_unit.sv
`timescale 1ns/1ps
module sim_bitfield_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [31:0] opnd_a = 32'd0;
    logic [31:0] opnd_b = 32'd0;
    logic [4:0]  src_pos = 5'd0;
    logic [4:0]  dst_pos = 5'd0;
    logic [4:0]  fld_width = 5'd0;
    logic [31:0] result;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    bit          have_exp = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    bitfield_unit u0 (
        .clk(clk), .rst(rst), .mode(mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .src_pos(src_pos), .dst_pos(dst_pos), .fld_width(fld_width), .result(result)
    );

    // Bit-by-bit reference, written from the requirements
    function automatic logic [31:0] model(int m, longint a, logic [31:0] b,
                                          int s, int d, int w);
        logic [31:0] fld = 32'd0;
        logic [31:0] out = 32'd0;
        longint      epos;
        longint      spos;
        if (m == 3) return 32'd0;                               // R9
        epos = (m == 1) ? a : s;
        spos = (m == 2) ? a : d;
        if (m != 0 && (epos >= 32 || spos >= 32)) return 32'd0;  // R7
        for (int i = 0; i < w; i++)
            if (epos + i < 32) fld[i] = b[epos + i];
        if (m == 0) begin                                        // R3
            out = a[31:0];
            for (int j = 0; j < 32; j++)
                if (j >= d && j - d < w) out[j] = fld[j - d];
        end else begin
            for (int j = 0; j < 32; j++)
                if (j >= spos) out[j] = fld[j - spos];           // R8
        end
        return out;
    endfunction

    task automatic check(input string tag, input logic [31:0] exp);
        total++;
        if (result !== exp) begin
            bad++;
            $display("FAIL %s: result=%08h expected=%08h", tag, result, exp);
        end
    endtask

    // Every falling edge: check what the last edge latched, then drive the next operation
    task automatic step(input int m, input logic [31:0] a, input logic [31:0] b,
                        input int s, input int d, input int w, input string tag);
        @(negedge clk);
        if (have_exp) check(tag_q.pop_front(), exp_q.pop_front());
        mode = m[1:0]; opnd_a = a; opnd_b = b;
        src_pos = s[4:0]; dst_pos = d[4:0]; fld_width = w[4:0];
        exp_q.push_back(model(m, {32'd0, a}, b, s, d, w));
        tag_q.push_back(tag);
        have_exp = 1'b1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_exp) check({"R2 ", tag_q.pop_front()}, exp_q.pop_front());
        have_exp = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        mode = 2'd3; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
        fld_width = 5'd31;
        repeat (3) begin
            @(negedge clk);
            check("R1 reset", 32'd0);
        end
        rst = 1'b0;
        // Insert cases
        step(0, 32'hFFFF_FFFF, 32'h0000_00A5, 0, 8, 8, "R3 insert mid");
        step(0, 32'h1234_5678, 32'hF000_0000, 28, 0, 4, "R3 insert from top");
        step(0, 32'h0000_0000, 32'hFFFF_FFFF, 0, 28, 8, "R8 insert past bit 31");
        step(0, 32'hCAFE_BABE, 32'hFFFF_FFFF, 0, 3, 0, "R4 insert width 0");
        step(0, 32'h0000_0000, 32'hFFFF_FFFF, 31, 0, 31, "R8 source past bit 31");
        step(0, 32'hAAAA_AAAA, 32'h5555_5555, 1, 0, 31, "R4 width 31");
        // Dynamic position
        step(1, 32'd4, 32'h0000_0FF0, 0, 16, 8, "R5 dyn pos");
        step(1, 32'd31, 32'h8000_0000, 0, 0, 31, "R5 dyn pos top bit");
        step(1, 32'd32, 32'hFFFF_FFFF, 0, 0, 8, "R7 dyn pos 32");
        step(1, 32'h0000_0103, 32'hFFFF_FFFF, 0, 0, 8, "R7 dyn pos high bits");
        step(1, 32'd0, 32'hFFFF_FFFF, 0, 0, 0, "R4 dyn pos width 0");
        // Dynamic shift
        step(2, 32'd12, 32'h0000_ABCD, 4, 0, 8, "R6 dyn shift");
        step(2, 32'd31, 32'h0000_0003, 0, 0, 2, "R8 dyn shift drop");
        step(2, 32'd32, 32'hFFFF_FFFF, 0, 0, 4, "R7 dyn shift 32");
        step(2, 32'hFFFF_FFE1, 32'hFFFF_FFFF, 0, 0, 4, "R7 dyn shift high bits");
        // Unused mode
        step(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 9, "R9 mode 3");
        // Mixed random traffic
        for (int n = 0; n < 600; n++) begin
            int          m = int'($urandom_range(0, 3));
            logic [31:0] a = $urandom();
            if (n % 3 != 0 && (m == 1 || m == 2)) a = {27'd0, a[4:0]};
            step(m, a, $urandom(), int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                 (m == 0) ? "R3 random insert" :
                 (m == 1) ? "R5 random dyn pos" :
                 (m == 2) ? "R6 random dyn shift" : "R9 random mode 3");
        end
        flush();
        // Reset in the middle of traffic
        mode = 2'd0; opnd_a = 32'hDEAD_BEEF; fld_width = 5'd0;
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R4 after reset insert width 0", 32'hDEAD_BEEF);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: result=%08h expected=completion", result);
            finish_run();
        end
    end
endmodule